// File: doc/BRIEF.md
# Prescaled Four-Channel Pulse-Width Modulator

This block produces four pulse-width modulated outputs that share one free-running counter. A scale field picks how many low counter bits are dropped before the count is compared against the compare value of each channel. The comparators have a fixed width, so the scale is the only way to set the period. Each period lasts `2^(CMP_W+scale)` clock ticks. The duty fraction of a channel is its compare value divided by `2^CMP_W`. That fraction is the part of the period during which the output sits at its low (active) level. The outputs are active-low only. A 100% duty cycle cannot be produced, because even the largest compare value leaves the output high for the last scaled step of every period.

Software controls the block through a small register bus with byte addresses on word boundaries. Reads are combinational and writes are taken on the clock edge. The counter runs in one of two modes: a continuous mode, or a one-shot mode that runs for a single period and then stops. Software reads the counter back either raw or after the scale shift. The scale and the compare values are written as separate bus writes, so one period may combine a new length with an old duty.

Top module: `pwm_quad`

## Requirements
- R1: After synchronous reset, the configuration register, the raw count, the scaled count and all four compare registers read zero, and all outputs are high.
- R2: The configuration register at byte offset 0x00 holds the scale in bits [SCALE_W-1:0], the continuous-run enable in bit 12 and the one-shot request in bit 13, and every other bit reads zero. The compare register of channel i is at byte offset 0x20 + 4*i, holds CMP_W bits, and its upper bits read zero.
- R3: While bit 12 or bit 13 is set, the raw count at offset 0x08 advances by one on every clock. While both bits are clear, the count is held at zero, and it returns to zero on the clock after the last enable clears.
- R4: Once the raw count reaches `2^(CMP_W+scale)-1`, it wraps to zero on the next clock, so one period lasts `2^(CMP_W+scale)` cycles.
- R5: The scaled count at offset 0x10 reads the raw count shifted right by the scale, truncated to CMP_W bits.
- R6: One clock after the counter holds value c while running, output i is low when `(c >> scale) < compare[i]` and high otherwise. A compare value of zero keeps the output high, and the maximum compare value leaves it high for the final scaled step of each period. While the counter is stopped, every output is high.
- R7: When bit 13 is set on its own, the counter runs exactly one period from zero, then bit 13 clears and the count stays at zero. A bus write to the configuration register in the same cycle as the period end takes priority over that clear.
- R8: Writes to the two count offsets and to any unmapped or misaligned offset change no register, and reads of unmapped or misaligned offsets return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, taken on the rising clock edge |
| bus_addr | input | 8 | Byte address, shared by reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pwm_n | output | 4 | Active-low channel outputs, registered |

## Verification
The assertions check on every cycle the counter step rules: advance by one, wrap to zero at the end of the period, and hold at zero when idle. They also check that the one-shot bit clears at the end of its period unless a write overrides it, that stopped channels stay high, and that a zero compare value keeps its output high. Several behaviours can only be shown by the bench's scenarios. These are the duty pattern at each scale, the exact period lengths, the scaled readback, the field masking on readback, the point where a one-shot run stops, and the effect of stray writes, all set against counts the bench works out arithmetically over a reduced comparator width.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;

    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 32;
    localparam int NCH        = 4;
    localparam int IDX_W      = $clog2(NCH);
    localparam int CMP_STRIDE = 4;

    localparam logic [ADDR_W-1:0] OFS_CFG     = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_RAW     = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_SCL     = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_CMP     = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_CMP_END = ADDR_W'(int'(OFS_CMP) + NCH * CMP_STRIDE);

    localparam int BIT_LOOP = 12;
    localparam int BIT_ONCE = 13;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CFG,
        SEL_RAW,
        SEL_SCL,
        SEL_CMP
    } sel_e;

    typedef struct packed {
        sel_e             sel;
        logic [IDX_W-1:0] idx;
    } dec_t;

    function automatic dec_t decode(input logic [ADDR_W-1:0] a);
        dec_t d;
        logic [ADDR_W-1:0] rel;
        d.sel = SEL_NONE;
        d.idx = '0;
        rel   = a - OFS_CMP;
        if (a[1:0] == 2'b00) begin
            if (a == OFS_CFG)
                d.sel = SEL_CFG;
            else if (a == OFS_RAW)
                d.sel = SEL_RAW;
            else if (a == OFS_SCL)
                d.sel = SEL_SCL;
            else if (a >= OFS_CMP && a < OFS_CMP_END) begin
                d.sel = SEL_CMP;
                d.idx = IDX_W'(rel >> 2);
            end
        end
        return d;
    endfunction

endpackage

// File: rtl/pwm_quad_regs.sv
module pwm_quad_regs
    import pwm_quad_pkg::*;
#(
    parameter int CMP_W   = 16,
    parameter int SCALE_W = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [DATA_W-1:0]             wdata,
    input  logic                          once_done,
    output logic [SCALE_W-1:0]            scale,
    output logic                          run_loop,
    output logic                          run_once,
    output logic [NCH-1:0][CMP_W-1:0]     cmp
);

    dec_t wdec;
    logic cfg_wr;
    logic [CMP_W-1:0] cmp_q [NCH];
    wire  unused_wbits = ^wdata;

    assign wdec   = decode(addr);
    assign cfg_wr = wr_en && (wdec.sel == SEL_CFG);

    always_ff @(posedge clk) begin
        if (rst) begin
            scale    <= '0;
            run_loop <= 1'b0;
            run_once <= 1'b0;
        end else if (cfg_wr) begin
            scale    <= wdata[SCALE_W-1:0];
            run_loop <= wdata[BIT_LOOP];
            run_once <= wdata[BIT_ONCE];
        end else if (once_done) begin
            run_once <= 1'b0;
        end
    end

    for (genvar i = 0; i < NCH; i++) begin : g_cmp
        always_ff @(posedge clk) begin
            if (rst)
                cmp_q[i] <= '0;
            else if (wr_en && wdec.sel == SEL_CMP && wdec.idx == IDX_W'(i))
                cmp_q[i] <= wdata[CMP_W-1:0];
        end
        assign cmp[i] = cmp_q[i];
    end

    // R7: the one-shot request drops after its period unless a config write lands in the same cycle
    assert_once_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (once_done && !cfg_wr) |=> !run_once);

endmodule

// File: rtl/pwm_quad_counter.sv
module pwm_quad_counter #(
    parameter int CMP_W   = 16,
    parameter int SCALE_W = 4,
    localparam int CNT_W  = CMP_W + (1 << SCALE_W) - 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               run_loop,
    input  logic               run_once,
    input  logic [SCALE_W-1:0] scale,
    output logic [CNT_W-1:0]   cnt,
    output logic [CMP_W-1:0]   scaled,
    output logic               running,
    output logic               once_done
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] mask;
    logic             wrap;

    assign mask      = (ONE << (CMP_W + int'(scale))) - ONE;
    assign wrap      = (cnt & mask) == mask;
    assign running   = run_loop | run_once;
    assign once_done = run_once & wrap;
    assign scaled    = CMP_W'(cnt >> scale);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (!running || wrap)
            cnt <= '0;
        else
            cnt <= cnt + ONE;
    end

    // R3: a running counter that is not at its period end steps by one
    assert_step_R3: assert property (@(posedge clk) disable iff (rst)
        (running && !wrap) |=> cnt == $past(cnt) + ONE);

    // R3: an idle counter sits at zero on the following cycle
    assert_idle_zero_R3: assert property (@(posedge clk) disable iff (rst)
        !running |=> cnt == '0);

    // R4: the period end returns the count to zero
    assert_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (running && wrap) |=> cnt == '0);

endmodule

// File: rtl/pwm_quad_chan.sv
module pwm_quad_chan #(
    parameter int CMP_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             running,
    input  logic [CMP_W-1:0] scaled,
    input  logic [CMP_W-1:0] cmp,
    output logic             out_n
);

    logic active;

    assign active = running && (scaled < cmp);

    always_ff @(posedge clk) begin
        if (rst)
            out_n <= 1'b1;
        else
            out_n <= ~active;
    end

    // R6: a stopped counter leaves the output at its idle high level
    assert_idle_high_R6: assert property (@(posedge clk) disable iff (rst)
        !running |=> out_n);

    // R6: a zero compare value never drives the output low
    assert_zero_cmp_R6: assert property (@(posedge clk) disable iff (rst)
        (cmp == '0) |=> out_n);

endmodule

// File: rtl/pwm_quad.sv
module pwm_quad
    import pwm_quad_pkg::*;
#(
    parameter int CMP_W   = 16,
    parameter int SCALE_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [3:0]        pwm_n
);

    localparam int CNT_W = CMP_W + (1 << SCALE_W) - 1;

    logic [SCALE_W-1:0]        scale;
    logic                      run_loop;
    logic                      run_once;
    logic [NCH-1:0][CMP_W-1:0] cmp;
    logic [CNT_W-1:0]          cnt;
    logic [CMP_W-1:0]          scaled;
    logic                      running;
    logic                      once_done;
    dec_t                      rdec;

    pwm_quad_regs #(.CMP_W(CMP_W), .SCALE_W(SCALE_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .once_done (once_done),
        .scale     (scale),
        .run_loop  (run_loop),
        .run_once  (run_once),
        .cmp       (cmp)
    );

    pwm_quad_counter #(.CMP_W(CMP_W), .SCALE_W(SCALE_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .run_loop  (run_loop),
        .run_once  (run_once),
        .scale     (scale),
        .cnt       (cnt),
        .scaled    (scaled),
        .running   (running),
        .once_done (once_done)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        pwm_quad_chan #(.CMP_W(CMP_W)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .running (running),
            .scaled  (scaled),
            .cmp     (cmp[i]),
            .out_n   (pwm_n[i])
        );
    end

    assign rdec = decode(bus_addr);

    always_comb begin
        bus_rdata = '0;
        unique case (rdec.sel)
            SEL_CFG: begin
                bus_rdata[SCALE_W-1:0] = scale;
                bus_rdata[BIT_LOOP]    = run_loop;
                bus_rdata[BIT_ONCE]    = run_once;
            end
            SEL_RAW:  bus_rdata = DATA_W'(cnt);
            SEL_SCL:  bus_rdata = DATA_W'(scaled);
            SEL_CMP:  bus_rdata = DATA_W'(cmp[rdec.idx]);
            default:  bus_rdata = '0;
        endcase
    end

endmodule

// File: tb/pwm_quad_test.sv
`timescale 1ns/1ps
module pwm_quad_test;

    localparam int CW = 4;
    localparam int SW = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  pwm_n;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;
    int cmpv [4];

    always #2.5 clk = ~clk;

    pwm_quad #(.CMP_W(CW), .SCALE_W(SW)) uut (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (wr),
        .bus_addr  (addr),
        .bus_wdata (wdata),
        .bus_rdata (rdata),
        .pwm_n     (pwm_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
        addr  = a;
        wdata = d;
        wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr    = 1'b0;
    endtask

    task automatic rd_reg(input logic [7:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    function automatic logic [3:0] exp_out(input int c, input int s, input bit run);
        logic [3:0] e;
        e = 4'hF;
        if (run)
            for (int i = 0; i < 4; i++)
                e[i] = ((c >> s) < cmpv[i]) ? 1'b0 : 1'b1;
        return e;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int p;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset values
        rd_reg(8'h00, d); chk("R1 cfg", d, 32'h0);
        rd_reg(8'h08, d); chk("R1 raw", d, 32'h0);
        rd_reg(8'h10, d); chk("R1 scaled", d, 32'h0);
        for (int i = 0; i < 4; i++) begin
            rd_reg(8'h20 + 8'(4 * i), d); chk("R1 cmp", d, 32'h0);
        end
        chk("R1 outputs", {28'h0, pwm_n}, 32'hF);

        // R2: field masking on readback
        wr_reg(8'h00, 32'hFFFF_CFFF);
        rd_reg(8'h00, d); chk("R2 cfg mask", d, 32'h3);
        for (int i = 0; i < 4; i++) begin
            wr_reg(8'h20 + 8'(4 * i), 32'hABCD_0000 | 32'(i + 5));
            rd_reg(8'h20 + 8'(4 * i), d); chk("R2 cmp mask", d, 32'(i + 5));
        end
        rd_reg(8'h08, d); chk("R3 idle hold", d, 32'h0);

        // R8: stray writes and unmapped reads
        wr_reg(8'h04, 32'hFFFF_FFFF);
        wr_reg(8'h0C, 32'hFFFF_FFFF);
        wr_reg(8'h30, 32'hFFFF_FFFF);
        wr_reg(8'h21, 32'hFFFF_FFFF);
        wr_reg(8'h08, 32'hFFFF_FFFF);
        wr_reg(8'h10, 32'hFFFF_FFFF);
        rd_reg(8'h04, d); chk("R8 read 0x04", d, 32'h0);
        rd_reg(8'h30, d); chk("R8 read 0x30", d, 32'h0);
        rd_reg(8'h21, d); chk("R8 read 0x21", d, 32'h0);
        rd_reg(8'h00, d); chk("R8 cfg kept", d, 32'h3);
        rd_reg(8'h08, d); chk("R8 raw kept", d, 32'h0);
        rd_reg(8'h10, d); chk("R8 scaled kept", d, 32'h0);
        for (int i = 0; i < 4; i++) begin
            rd_reg(8'h20 + 8'(4 * i), d); chk("R8 cmp kept", d, 32'(i + 5));
        end
        chk("R8 outputs idle", {28'h0, pwm_n}, 32'hF);

        // continuous runs over every scale
        for (int s = 0; s < 4; s++) begin
            p = 1 << (CW + s);
            cmpv[0] = 0;
            cmpv[1] = s * 4 + 1;
            cmpv[2] = 8 - s;
            cmpv[3] = 15;
            for (int i = 0; i < 4; i++)
                wr_reg(8'h20 + 8'(4 * i), 32'(cmpv[i]));
            wr_reg(8'h00, 32'h1000 | 32'(s));
            for (int k = 0; k < p + 3; k++) begin
                rd_reg(8'h08, d);
                chk("R3 R4 raw count", d, 32'(k % p));
                if (k == 0)
                    chk("R6 first cycle idle", {28'h0, pwm_n}, 32'hF);
                else
                    chk("R6 duty", {28'h0, pwm_n}, {28'h0, exp_out((k - 1) % p, s, 1'b1)});
                @(negedge clk);
            end
            for (int k = p + 3; k < 2 * p + 3; k++) begin
                rd_reg(8'h10, d);
                chk("R5 scaled count", d, 32'((k % p) >> s));
                chk("R6 duty", {28'h0, pwm_n}, {28'h0, exp_out((k - 1) % p, s, 1'b1)});
                @(negedge clk);
            end
            wr_reg(8'h00, 32'(s));
            @(negedge clk);
            rd_reg(8'h08, d); chk("R3 stop to zero", d, 32'h0);
            chk("R6 stopped idle", {28'h0, pwm_n}, 32'hF);
        end

        // R7: single period run at scale 1
        cmpv[0] = 3; cmpv[1] = 0; cmpv[2] = 15; cmpv[3] = 9;
        for (int i = 0; i < 4; i++)
            wr_reg(8'h20 + 8'(4 * i), 32'(cmpv[i]));
        p = 1 << (CW + 1);
        wr_reg(8'h00, 32'h2000 | 32'h1);
        for (int k = 0; k < p + 5; k++) begin
            rd_reg(8'h08, d);
            chk("R7 one-shot count", d, (k < p) ? 32'(k) : 32'h0);
            if (k == 0)
                chk("R7 output", {28'h0, pwm_n}, 32'hF);
            else
                chk("R7 output", {28'h0, pwm_n}, {28'h0, exp_out(k - 1, 1, (k - 1) < p)});
            @(negedge clk);
        end
        rd_reg(8'h00, d); chk("R7 one-shot bit cleared", d, 32'h1);

        // R7: a config write at the period end keeps the one-shot alive
        p = 1 << CW;
        wr_reg(8'h00, 32'h2000);
        for (int k = 0; k < p - 1; k++) begin
            rd_reg(8'h08, d); chk("R7 count before end", d, 32'(k));
            @(negedge clk);
        end
        rd_reg(8'h08, d); chk("R7 count at end", d, 32'(p - 1));
        wr_reg(8'h00, 32'h2000);
        rd_reg(8'h00, d); chk("R7 write wins over clear", d, 32'h2000);
        @(negedge clk);
        rd_reg(8'h08, d); chk("R7 restarted count", d, 32'h1);
        wr_reg(8'h00, 32'h0);
        @(negedge clk);
        rd_reg(8'h08, d); chk("R3 cleared to zero", d, 32'h0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule